// File: doc/BRIEF.md
# Frame Adjustment Counter with Capture

This block measures how many frame-sync strobes occur over a window made of a fixed number of frame-start strobes. Software programs the window length as a reference count. The window closes when the frame-start count reaches that reference. At that moment the sync count gathered during the window is copied into a capture register that software can read. The block then sets a status flag, and it can raise an interrupt.

The block has two operating modes. In repeating mode a new window opens as soon as the previous one closes, so the capture register always holds the result of the most recent window. In one-shot mode the block stops after one capture and waits until software reads the capture register. Clearing the enable bit acts as a software reset. It clears both counters, the capture register and the status flag, and it releases a one-shot wait.

Access is through a small synchronous register bus with read and write strobes, a 2-bit address and 16-bit data. The two strobe inputs must already be synchronous to `clk`.

Top module: `frame_adj_counter`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: The register map is as follows. Address 0 is control: bit 2 is the interrupt enable, bit 1 is the enable (RUN), bit 0 is the mode (1 repeating, 0 one-shot), and bits 15:3 read 0. Address 1 is status: bit 0 is the capture-full flag. Address 2 is the 16-bit reference count, readable and writable. Address 3 is the capture register, read-only.
- R3: Only a rising edge on a strobe input counts, so a level held high for several cycles counts once. When the frame-start count of the current window reaches the reference, the capture register takes the number of sync edges seen in that window. A reference of 0 never captures.
- R4: In repeating mode, counting continues after a capture and each later window overwrites the capture register.
- R5: In one-shot mode, after a capture both counters stay frozen and the capture register holds its value. This lasts until software reads address 3. The next window then begins from zero.
- R6: The capture-full flag sets on every capture and clears when address 3 is read.
- R7: `irq` is a level equal to capture-full AND interrupt enable AND RUN. With the interrupt enable at 0 it stays low in both modes.
- R8: With RUN at 0, one cycle after the write both counters, the capture register and the capture-full flag are 0 and `irq` is low. A one-shot wait is cancelled, so counting resumes once RUN is set again, whether or not address 3 was read.
- R9: A sync edge that arrives in the same cycle as the closing frame-start edge counts toward the new window, not the captured one.
- R10: The sync counter saturates at 0xFFFF and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading address 3 clears the capture-full flag) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| frame_start_in | input | 1 | Frame-start strobe level |
| frame_sync_in | input | 1 | Frame-sync strobe level |
| irq | output | 1 | Interrupt level |

## Verification
The assertions assume that both strobe levels are synchronous to `clk`, so each rising level is seen exactly once. They also assume that RUN changes only through a bus write, and that reads and writes never fall in the same cycle. The bench changes every input on the falling clock edge. It drops each strobe back low for at least one cycle before raising it again, and it never overlaps a read with a write. The only case where the two strobes rise together is the deliberate test of the closing cycle.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] A_REF    = 2'd2;
  localparam logic [ADDR_W-1:0] A_FSC    = 2'd3;

  // bit 2 interrupt enable, bit 1 run, bit 0 repeat mode
  typedef struct packed {
    logic irq_en;
    logic run;
    logic repeat_mode;
  } fac_ctrl_t;

  typedef enum logic {
    ST_COUNT = 1'b0,
    ST_HOLD  = 1'b1
  } fac_state_e;
endpackage

// File: rtl/fac_edge_pulse.sv
module fac_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign pulse_o = level_i & ~prev_q;
endmodule

// File: rtl/fac_window_ctrl.sv
module fac_window_ctrl
  import fac_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             repeat_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             start_pulse_i,
  input  logic             sync_pulse_i,
  input  logic             fsc_rd_i,
  output logic             capture_o,
  output logic [CNT_W-1:0] fsc_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  fac_state_e       st_q, st_n;
  logic [CNT_W-1:0] start_q, start_n;
  logic [CNT_W-1:0] sync_q, sync_n;
  logic [CNT_W-1:0] fsc_q, fsc_n;
  logic [CNT_W-1:0] start_inc, sync_inc;
  logic             cap;

  assign start_inc = (start_q == CNT_MAX) ? start_q : start_q + 1'b1;
  assign sync_inc  = (sync_q  == CNT_MAX) ? sync_q  : sync_q  + 1'b1;

  always_comb begin
    st_n    = st_q;
    start_n = start_q;
    sync_n  = sync_q;
    fsc_n   = fsc_q;
    cap     = 1'b0;
    if (!run_i) begin
      st_n    = ST_COUNT;
      start_n = '0;
      sync_n  = '0;
      fsc_n   = '0;
    end else if (st_q == ST_HOLD) begin
      if (fsc_rd_i) st_n = ST_COUNT;
    end else begin
      if (sync_pulse_i) sync_n = sync_inc;
      if (start_pulse_i) begin
        if (start_inc == ref_i) begin
          cap     = 1'b1;
          fsc_n   = sync_q;
          start_n = '0;
          sync_n  = sync_pulse_i ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
          if (!repeat_i) st_n = ST_HOLD;
        end else begin
          start_n = start_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_COUNT;
      start_q <= '0;
      sync_q  <= '0;
      fsc_q   <= '0;
    end else begin
      st_q    <= st_n;
      start_q <= start_n;
      sync_q  <= sync_n;
      fsc_q   <= fsc_n;
    end
  end

  assign capture_o = cap;
  assign fsc_o     = fsc_q;

  // R8
  clear_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (start_q == '0) && (sync_q == '0) && (fsc_q == '0) && (st_q == ST_COUNT));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && st_q == ST_HOLD && !fsc_rd_i) |=> (st_q == ST_HOLD) && $stable(fsc_q) && $stable(sync_q));

  // R4
  repeat_keeps_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && repeat_i) |=> (st_q == ST_COUNT));

  // R10
  sync_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cap && sync_q == CNT_MAX) |=> (sync_q == CNT_MAX));
endmodule

// File: rtl/fac_regs.sv
module fac_regs
  import fac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] fsc_i,
  input  logic              capture_i,
  output fac_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] ref_o,
  output logic              fsc_rd_o,
  output logic              irq_o
);
  localparam int CTRL_W = $bits(fac_ctrl_t);

  fac_ctrl_t         ctrl_q, ctrl_n;
  logic [DATA_W-1:0] ref_q, ref_n;
  logic              full_q, full_n;
  logic              fsc_rd;

  assign fsc_rd = rd_en && (addr == A_FSC);

  always_comb begin
    ctrl_n = ctrl_q;
    ref_n  = ref_q;
    if (wr_en) begin
      if (addr == A_CTRL) ctrl_n = fac_ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == A_REF)  ref_n  = wdata;
    end
  end

  always_comb begin
    full_n = full_q;
    if (!ctrl_q.run)  full_n = 1'b0;
    else if (capture_i) full_n = 1'b1;
    else if (fsc_rd)    full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
      full_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      ref_q  <= ref_n;
      full_q <= full_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_STATUS: rdata[0]          = full_q;
      A_REF:    rdata             = ref_q;
      default:  rdata             = fsc_i;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign ref_o    = ref_q;
  assign fsc_rd_o = fsc_rd;
  assign irq_o    = full_q & ctrl_q.irq_en & ctrl_q.run;

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> full_q);

  // R6
  full_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsc_rd && !capture_i) |=> !full_q);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq_o);
endmodule

// File: rtl/frame_adj_counter.sv
module frame_adj_counter
  import fac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              frame_start_in,
  input  logic              frame_sync_in,
  output logic              irq
);
  localparam int N_STROBE = 2;
  localparam int IDX_START = 0;
  localparam int IDX_SYNC  = 1;

  logic [N_STROBE-1:0] levels;
  logic [N_STROBE-1:0] pulses;
  fac_ctrl_t           ctrl;
  logic [DATA_W-1:0]   ref_cnt;
  logic [DATA_W-1:0]   fsc;
  logic                capture;
  logic                fsc_rd;

  assign levels[IDX_START] = frame_start_in;
  assign levels[IDX_SYNC]  = frame_sync_in;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_edge
    fac_edge_pulse u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (levels[g]),
      .pulse_o (pulses[g])
    );
  end

  fac_window_ctrl #(.CNT_W(DATA_W)) u_win (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (ctrl.run),
    .repeat_i      (ctrl.repeat_mode),
    .ref_i         (ref_cnt),
    .start_pulse_i (pulses[IDX_START]),
    .sync_pulse_i  (pulses[IDX_SYNC]),
    .fsc_rd_i      (fsc_rd),
    .capture_o     (capture),
    .fsc_o         (fsc)
  );

  fac_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .fsc_i     (fsc),
    .capture_i (capture),
    .ctrl_o    (ctrl),
    .ref_o     (ref_cnt),
    .fsc_rd_o  (fsc_rd),
    .irq_o     (irq)
  );

  // R3
  capture_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (frame_start_in && !$past(frame_start_in)));
endmodule

// File: tb/frame_adj_counter_bench.sv
module frame_adj_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        frame_start_in, frame_sync_in;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frame_adj_counter u_frame_adj_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .frame_start_in(frame_start_in),
    .frame_sync_in(frame_sync_in), .irq(irq)
  );

  // {reference, syncs per frame, expected capture}
  localparam logic [47:0] VECS [0:3] = '{
    {16'd1, 16'd0, 16'd0},
    {16'd1, 16'd5, 16'd5},
    {16'd3, 16'd2, 16'd6},
    {16'd4, 16'd3, 16'd12}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic sync_pulse(input int hold);
    frame_sync_in = 1'b1;
    repeat (hold) tick();
    frame_sync_in = 1'b0;
    tick();
  endtask

  task automatic start_pulse();
    frame_start_in = 1'b1;
    tick();
    frame_start_in = 1'b0;
    tick();
  endtask

  task automatic frames(input int n, input int k);
    for (int f = 0; f < n; f++) begin
      for (int s = 0; s < k; s++) sync_pulse(2);
      start_pulse();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    frame_start_in = 1'b0; frame_sync_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], v); chk("R1 reset reg", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);

    // R2 register map
    wr(2'd0, 16'hFFF8); peek(2'd0, v); chk("R2 ctrl reserved", v, 16'h0000);
    wr(2'd0, 16'h0005); peek(2'd0, v); chk("R2 ctrl bits", v, 16'h0005);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hA5C3); peek(2'd2, v); chk("R2 ref rw", v, 16'hA5C3);
    wr(2'd3, 16'h1234); peek(2'd3, v); chk("R2 fsc read-only", v, 16'h0000);

    // R3/R4 vector table, repeating mode with interrupt
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 16'h0000);
      wr(2'd2, VECS[i][47:32]);
      wr(2'd0, 16'h0007);
      frames(int'(VECS[i][47:32]), int'(VECS[i][31:16]));
      rd(2'd3, v); chk("R3 window capture", v, VECS[i][15:0]);
      peek(2'd1, v); chk("R6 cleared by read", v, 16'h0000);
      frames(int'(VECS[i][47:32]), int'(VECS[i][31:16]));
      peek(2'd3, v); chk("R4 recapture", v, VECS[i][15:0]);
      peek(2'd1, v); chk("R6 set on capture", v, 16'h0001);
      chk("R7 irq on", {15'd0, irq}, 16'h0001);
    end

    // R5 one-shot mode
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0006);
    frames(2, 3);
    peek(2'd3, v); chk("R5 first capture", v, 16'd6);
    frames(2, 1);
    peek(2'd3, v); chk("R5 held while waiting", v, 16'd6);
    peek(2'd1, v); chk("R5 flag held", v, 16'h0001);
    rd(2'd3, v); chk("R5 read value", v, 16'd6);
    peek(2'd1, v); chk("R6 read clears", v, 16'h0000);
    chk("R7 irq off after read", {15'd0, irq}, 16'h0000);
    frames(2, 1);
    peek(2'd3, v); chk("R5 resumes after read", v, 16'd2);

    // R7 interrupt enable off
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0003);
    frames(1, 1);
    peek(2'd1, v); chk("R7 flag without irq", v, 16'h0001);
    chk("R7 irq masked", {15'd0, irq}, 16'h0000);
    wr(2'd0, 16'h0007);
    chk("R7 irq level when enabled", {15'd0, irq}, 16'h0001);

    // R8 stop clears everything
    wr(2'd0, 16'h0005);
    tick();
    peek(2'd3, v); chk("R8 fsc cleared", v, 16'h0000);
    peek(2'd1, v); chk("R8 flag cleared", v, 16'h0000);
    chk("R8 irq dropped", {15'd0, irq}, 16'h0000);
    // counters cleared mid-window
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0007);
    frames(1, 3);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0007);
    frames(2, 1);
    peek(2'd3, v); chk("R8 counters cleared", v, 16'd2);
    // one-shot wait cancelled without read
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0002);
    frames(1, 1);
    peek(2'd3, v); chk("R8 one-shot capture", v, 16'd1);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0002);
    frames(1, 2);
    peek(2'd3, v); chk("R8 resumes without read", v, 16'd2);

    // R9 sync edge in closing cycle
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0003);
    sync_pulse(1); sync_pulse(1);
    frame_sync_in = 1'b1; frame_start_in = 1'b1;
    tick();
    frame_sync_in = 1'b0; frame_start_in = 1'b0;
    tick();
    peek(2'd3, v); chk("R9 closing window", v, 16'd2);
    start_pulse();
    peek(2'd3, v); chk("R9 carried into new window", v, 16'd1);

    // R10 saturation
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    for (int n = 0; n < 65540; n++) sync_pulse(1);
    peek(2'd3, v); chk("R3 reference zero never captures", v, 16'h0000);
    wr(2'd2, 16'd1);
    start_pulse();
    peek(2'd3, v); chk("R10 sync saturates", v, 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule